// File: doc/BRIEF.md
# Asynchronous Static Memory Pin Front End

This block sits between the asynchronous control pins of a byte-wide static memory and the storage array behind them. It oversamples active-low chip select, write strobe and read strobe, an address bus and an incoming data byte on a fast internal clock. From those samples it decides three things: when a byte is stored, when stored data is driven out, and when the data pins float. The bidirectional data pins are split into a data-in byte, a data-out byte and a drive-enable, and the level above resolves the three-state bus. The storage array is a plain register array inside the block. Its size is set by the address-width parameter: a width of 13 gives the 8K by 8 arrangement, and the default elaborates a smaller array.

A store is the overlap of chip select low and write strobe low. The store opens at whichever of the two falls last. It takes the address present at that moment. It commits the last data byte seen while both strobes were low, and it does so when the first of the two rises. If the address moves while the overlap is open, the byte is dropped and a one-cycle flag is raised. When chip select falls while the write strobe is already low, or on the same sample, the data pins stay floating until chip select returns high. A write-protect input from a supply monitor overrides everything: no store happens and the pins float.

All pins pass through one sampling register. Edge detection compares that register with its previous value.

Top module: `sram_pin_front`

## Requirements
- R1: While the sampled chip select `ce_n` is 1, `dout_en` is 0 whatever `we_n` and `oe_n` are.
- R2: With `ce_n`=0, `we_n`=1 and `oe_n`=1, `dout_en` is 0.
- R3: With `ce_n`=0, `we_n`=1, `oe_n`=0, `wprot`=0 and no float hold pending (R6), `dout_en` is 1 and `dout` equals the byte stored at `addr`.
- R4: With `ce_n`=0 and `we_n`=0, a store window is open whatever `oe_n` is, and `dout_en` is 0.
- R5: A store window takes its address when the later of `ce_n` and `we_n` falls. It writes the last `din` sampled inside the window. The write happens when the earlier of the two rises, and either pin rising ends the window.
- R6: If `ce_n` falls on the same sample as `we_n` or after it, `dout_en` stays 0 until `ce_n` is sampled high again, even after `we_n` rises.
- R7: If `ce_n` falls while `we_n` is high, then once `we_n` rises and ends a store with `oe_n`=0, `dout_en` returns to 1 and shows the new byte.
- R8: While `wprot` is 1, `dout_en` is 0, no store window opens, and a window that is already open is dropped without writing.
- R9: If `addr` differs from the window address while the window is open, the window writes nothing when it closes. In that case `viol` is 1 for exactly one cycle, two clock edges after the closing pins are applied.
- R10: While `rst_n` is 0, `dout_en` and `viol` are 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| wprot | input | 1 | Write protect from the supply monitor, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data byte arriving from the pins |
| dout | output | DATA_W | Stored byte at the sampled address |
| dout_en | output | 1 | Drive enable for the data pins |
| viol | output | 1 | One-cycle pulse: store discarded because the address moved |

## Verification
The assertions compare the drive enable and the violation pulse with the pins as they stand after the sampling register. They therefore assume every pin holds steady for at least one fast-clock cycle, so that no level is missed between samples. The stimulus changes pins only on falling clock edges and holds each setting for at least two rising edges. Addresses come from a small fixed pool that is preloaded, so every read has a known expected byte.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic wprot;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, wprot: 1'b0};

endpackage

// File: rtl/slp_pin_sampler.sv
module slp_pin_sampler
    import slp_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          pins_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] din_i,
    output ctl_t          cur_o,
    output logic          prv_ce_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] din_o
);

    typedef struct packed {
        ctl_t          cur;
        logic          prv_ce_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.prv_ce_n = smp_q.cur.ce_n;
        smp_d.cur      = pins_i;
        smp_d.addr     = addr_i;
        smp_d.din      = din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q.cur      <= CTL_IDLE;
            smp_q.prv_ce_n <= 1'b1;
            smp_q.addr     <= '0;
            smp_q.din      <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign cur_o      = smp_q.cur;
    assign prv_ce_n_o = smp_q.prv_ce_n;
    assign addr_o     = smp_q.addr;
    assign din_o      = smp_q.din;

endmodule

// File: rtl/slp_write_window.sv
module slp_write_window
    import slp_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          cur_i,
    input  logic          prv_ce_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] din_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          viol_o,
    output logic          hold_o,
    output logic          open_o
);

    typedef struct packed {
        logic          open;
        logic          bad;
        logic          hold;
        logic          viol;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } win_t;

    win_t win_d, win_q;
    logic overlap;
    logic commit;

    always_comb begin
        win_d      = win_q;
        win_d.viol = 1'b0;
        commit     = 1'b0;
        overlap    = !cur_i.ce_n && !cur_i.we_n && !cur_i.wprot;

        if (cur_i.wprot) begin
            win_d.open = 1'b0;
            win_d.bad  = 1'b0;
        end else if (!win_q.open && overlap) begin
            win_d.open  = 1'b1;
            win_d.bad   = 1'b0;
            win_d.waddr = addr_i;
            win_d.wdata = din_i;
        end else if (win_q.open && overlap) begin
            win_d.wdata = din_i;
            if (addr_i != win_q.waddr) begin
                win_d.bad = 1'b1;
            end
        end else if (win_q.open) begin
            win_d.open = 1'b0;
            win_d.bad  = 1'b0;
            win_d.viol = win_q.bad;
            commit     = !win_q.bad;
        end

        if (cur_i.ce_n) begin
            win_d.hold = 1'b0;
        end else if (prv_ce_n_i && !cur_i.we_n) begin
            win_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign wr_en_o   = commit && rst_n;
    assign wr_addr_o = win_q.waddr;
    assign wr_data_o = win_q.wdata;
    assign viol_o    = win_q.viol;
    assign hold_o    = win_q.hold;
    assign open_o    = win_q.open;

endmodule

// File: rtl/slp_byte_array.sv
module slp_byte_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cells[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/sram_pin_front.sv
module sram_pin_front
    import slp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wprot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              viol
);

    ctl_t              pins_c;
    ctl_t              cur_s;
    logic              prv_ce_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              hold_s;
    logic              open_s;

    assign pins_c = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, wprot: wprot};

    slp_pin_sampler #(.AW(ADDR_W), .DW(DATA_W)) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins_c),
        .addr_i     (addr),
        .din_i      (din),
        .cur_o      (cur_s),
        .prv_ce_n_o (prv_ce_n_s),
        .addr_o     (addr_s),
        .din_o      (din_s)
    );

    slp_write_window #(.AW(ADDR_W), .DW(DATA_W)) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (cur_s),
        .prv_ce_n_i (prv_ce_n_s),
        .addr_i     (addr_s),
        .din_i      (din_s),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .viol_o     (viol),
        .hold_o     (hold_s),
        .open_o     (open_s)
    );

    slp_byte_array #(.AW(ADDR_W), .DW(DATA_W)) i_array (
        .clk        (clk),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (addr_s),
        .rd_data_o  (dout)
    );

    assign dout_en = !cur_s.ce_n && cur_s.we_n && !cur_s.oe_n
                     && !cur_s.wprot && !hold_s;

endmodule

// File: rtl/sram_pin_front_chk.sv
module sram_pin_front_chk
    import slp_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input ctl_t smp,
    input logic hold,
    input logic open,
    input logic dout_en,
    input logic viol
);

    // R1
    p_deselect_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp.ce_n |-> !dout_en);

    // R2
    p_read_off_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.ce_n && smp.we_n && smp.oe_n) |-> !dout_en);

    // R3
    p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.ce_n && smp.we_n && !smp.oe_n && !smp.wprot && !hold) |-> dout_en);

    // R4
    p_overlap_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.ce_n && !smp.we_n && !smp.wprot) |=> open);

    p_overlap_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.ce_n && !smp.we_n) |-> !dout_en);

    // R6
    p_late_select_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.ce_n && !smp.we_n) |=> (hold || $past(!hold)) );

    p_hold_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !dout_en);

    // R8
    p_protect_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp.wprot |-> !dout_en);

    p_protect_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp.wprot |=> !open);

    // R9
    p_viol_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !viol);

    p_viol_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(open));

endmodule

bind sram_pin_front sram_pin_front_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp     (cur_s),
    .hold    (hold_s),
    .open    (open_s),
    .dout_en (dout_en),
    .viol    (viol)
);

// File: tb/test_sram_pin_front.sv
`timescale 1ns/1ps
module test_sram_pin_front;

    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wprot = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, viol;
    wire  [DW-1:0] bus;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [DW-1:0] model [0:(1<<AW)-1];

    always #5 clk = ~clk;

    assign bus = dout_en ? dout : {DW{1'bz}};

    sram_pin_front #(.ADDR_W(AW), .DATA_W(DW)) i_sram_pin_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wprot(wprot), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .viol(viol)
    );

    function automatic logic [AW-1:0] pool_addr(int i);
        return AW'((i * 37 + 5) % (1 << AW));
    endfunction

    function automatic logic exp_drive(logic c, logic w, logic o, logic p, logic hold);
        return !c && w && !o && !p && !hold;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(logic c, logic w, logic o, logic p, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; wprot = p; addr = a; din = d;
        settle();
    endtask

    task automatic idle();
        step(1, 1, 1, 0, addr, din);
    endtask

    task automatic read_chk(string tag, logic [AW-1:0] a);
        step(0, 1, 0, 0, a, 8'h00);
        chk({tag, " R3 drive"}, dout_en, 1'b1);
        chk({tag, " R3 data"}, bus, model[a]);
        idle();
    endtask

    task automatic we_write(logic [AW-1:0] a, logic [DW-1:0] d, logic o);
        step(0, 1, 1, 0, a, 8'h00);
        step(0, 0, o, 0, a, d);
        chk("R4 float in WE window", dout_en, 1'b0);
        step(0, 1, 1, 0, a, d);
        idle();
        model[a] = d;
    endtask

    task automatic ce_write(logic [AW-1:0] a, logic [DW-1:0] d, logic o);
        step(1, 0, o, 0, a, d);
        step(0, 0, o, 0, a, d);
        chk("R4 float in CE window", dout_en, 1'b0);
        step(1, 0, o, 0, a, d);
        idle();
        model[a] = d;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [AW-1:0] a, a2;
        void'($urandom(32'h5A17));

        // R10: pins look like a read and a store during reset
        ce_n = 0; we_n = 0; oe_n = 0; addr = pool_addr(0); din = 8'hEE;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 reset drive", dout_en, 1'b0);
        chk("R10 reset viol", viol, 1'b0);
        ce_n = 1; we_n = 1; oe_n = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        for (int i = 0; i < 16; i++) we_write(pool_addr(i), 8'(i * 11 + 3), 1'b1);
        read_chk("R10 no write in reset", pool_addr(0));

        // R1: deselected with read strobe and write strobe in all combos
        for (int k = 0; k < 4; k++) begin
            step(1, k[0], k[1], 0, pool_addr(1), 8'h77);
            chk("R1 deselect float", dout_en, 1'b0);
        end
        read_chk("R1 no store when deselected", pool_addr(1));

        // R2
        step(0, 1, 1, 0, pool_addr(2), 8'h00);
        chk("R2 output disabled", dout_en, 1'b0);
        idle();

        // R4: store with read strobe low, WE controlled, window ended by WE
        we_write(pool_addr(3), 8'hA5, 1'b0);
        read_chk("R4 R5 WE-ended store", pool_addr(3));

        // R5: CE-ended store; data changes inside the window, last value kept
        a = pool_addr(4);
        step(0, 1, 1, 0, a, 8'h00);
        step(0, 0, 1, 0, a, 8'h11);
        step(0, 0, 1, 0, a, 8'h22);
        step(1, 0, 1, 0, a, 8'h99);
        idle();
        model[a] = 8'h22;
        read_chk("R5 last data in window", a);

        // R6: CE falls after WE; float held after WE rises
        a = pool_addr(5);
        step(1, 0, 0, 0, a, 8'h3C);
        step(0, 0, 0, 0, a, 8'h3C);
        chk("R6 float during late-select window", dout_en, 1'b0);
        step(0, 1, 0, 0, a, 8'h3C);
        chk("R6 float held after WE rise", dout_en, 1'b0);
        model[a] = 8'h3C;
        idle();
        read_chk("R6 stored and released", a);

        // R6: simultaneous fall
        a = pool_addr(6);
        step(0, 0, 0, 0, a, 8'hC3);
        step(0, 1, 0, 0, a, 8'hC3);
        chk("R6 float held after same-sample fall", dout_en, 1'b0);
        model[a] = 8'hC3;
        idle();
        read_chk("R6 same-sample store", a);

        // R7: CE first, WE pulse, read resumes
        a = pool_addr(7);
        step(0, 1, 0, 0, a, 8'h00);
        chk("R7 read before store", dout_en, 1'b1);
        step(0, 0, 0, 0, a, 8'h5E);
        chk("R7 float during store", dout_en, 1'b0);
        step(0, 1, 0, 0, a, 8'h5E);
        model[a] = 8'h5E;
        chk("R7 drive resumes", dout_en, 1'b1);
        chk("R7 new byte shown", bus, 8'h5E);
        idle();

        // R8: protect aborts open window, blocks reads and stores
        a = pool_addr(8);
        step(0, 0, 1, 0, a, 8'hF0);
        step(0, 0, 1, 1, a, 8'hF0);
        step(0, 1, 1, 1, a, 8'hF0);
        step(1, 1, 1, 0, a, 8'hF0);
        read_chk("R8 aborted window kept old", a);
        step(0, 1, 0, 1, a, 8'h00);
        chk("R8 read blocked", dout_en, 1'b0);
        step(0, 0, 1, 1, a, 8'h0F);
        step(0, 1, 1, 1, a, 8'h0F);
        idle();
        read_chk("R8 store blocked", a);

        // R9: address moves inside window
        a = pool_addr(9);
        a2 = pool_addr(10);
        step(0, 0, 1, 0, a, 8'h66);
        step(0, 0, 1, 0, a2, 8'h66);
        chk("R9 no flag while open", viol, 1'b0);
        @(negedge clk);
        we_n = 1'b1;
        settle();
        chk("R9 flag pulse", viol, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 flag one cycle", viol, 1'b0);
        idle();
        read_chk("R9 first address kept", a);
        read_chk("R9 second address kept", a2);

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [DW-1:0] d;
            op = int'($urandom_range(0, 4));
            a  = pool_addr(int'($urandom_range(0, 15)));
            d  = DW'($urandom);
            case (op)
                0: we_write(a, d, 1'($urandom_range(0, 1)));
                1: ce_write(a, d, 1'($urandom_range(0, 1)));
                2: read_chk("random", a);
                3: begin
                    step(0, 1, 1, 1, a, d);
                    step(0, 0, 1, 1, a, d);
                    chk("R8 random protect", dout_en,
                        32'(exp_drive(0, 0, 1, 1, 0)));
                    step(0, 1, 1, 1, a, d);
                    idle();
                end
                default: begin
                    logic c, w, o;
                    c = 1'($urandom_range(0, 1));
                    w = 1'b1;
                    o = 1'($urandom_range(0, 1));
                    step(c, w, o, 0, a, d);
                    chk("R1 R2 R3 random levels", dout_en, 32'(exp_drive(c, w, o, 0, 0)));
                    if (dout_en) chk("R3 random data", bus, model[a]);
                    idle();
                end
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule